// File: doc/BRIEF.md
# Multi-Standard Serial Audio Transmitter

This block is a master-mode transmitter for stereo audio. It accepts a left and right sample pair over a valid/ready handshake and sends it out as serial data. It generates the bit clock and a word-select line itself. The word-select line becomes a frame-sync pulse when the short-frame or long-frame PCM framing is chosen. One shifter handles four framings: Philips (word select one bit ahead of the data), left-justified, right-justified and PCM. The data width is 16, 24 or 32 bits. The slot width is 16 or 32 bits.

Configuration is copied into internal registers on every clock while `enable` is low. It is frozen from the moment `enable` rises, so edits made while running have no effect until the next disable. Each run begins with a single lead-in bit and then sends frames of two slots, left first. The bench can hold `sampleValid` low when a pair is due. The previous pair is then sent again and a sticky underrun flag is raised.

Top module: `audio_ser_tx`

## Requirements
- R1: With `cfgStd`=00 (Philips), `ws` is low for the left channel and changes one bit clock before the MSB of each channel. The data follows MSB first.
- R2: With `cfgStd`=01 (left-justified), `ws` is low for the left slot and high for the right slot, and the MSB is sent in the first bit of the slot.
- R3: With `cfgStd`=10 (right-justified), the LSB is sent in the last bit of the slot. The leading unused bits of the slot are zero.
- R4: With `cfgStd`=11 (PCM), `ws` carries frame sync. When `cfgLongSync`=0 it is high for exactly the one bit before the first left data bit. When `cfgLongSync`=1 it is high for 13 bits, starting with that first bit. In the other standards `cfgLongSync` has no effect.
- R5: `sck` rests at the level of `cfgIdleHigh` while disabled. `sd` changes only as `sck` moves to its idle level, and the receiver samples on the opposite edge.
- R6: `cfgDataLen` 00/01/10 gives 16/24/32 data bits, taken from the low bits of each sample. For Philips, left-justified and PCM framing, the trailing unused slot bits are zero.
- R7: `cfgChan32` selects 16-bit (0) or 32-bit (1) slots only when the data length is 16. Otherwise the slots are 32 bits.
- R8: `cfgDataLen`=11 is sent as 16-bit data. `cfgError` is then high while enabled and clears once `enable` is low.
- R9: Configuration inputs and `clkDiv` that change while `enable` is high do not alter the output until after a disable.
- R10: `sampleReady` is high for a single clock once per frame, as the frame's first bit is launched. If `sampleValid` is low then, the previous pair is sent again and `underrun` is set until `enable` goes low.
- R11: Each half period of `sck` lasts `clkDiv`+1 clock cycles.
- R12: After reset, and while disabled, `ws`, `sd`, `sampleReady`, `underrun` and `cfgError` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run the transmitter. While low, the configuration is captured |
| cfgStd | input | 2 | Framing: 00 Philips, 01 left-justified, 10 right-justified, 11 PCM |
| cfgLongSync | input | 1 | PCM frame-sync length: 0 short, 1 long |
| cfgIdleHigh | input | 1 | Idle level of `sck` |
| cfgDataLen | input | 2 | Data width: 00 16, 01 24, 10 32, 11 illegal |
| cfgChan32 | input | 1 | Slot width for 16-bit data: 0 16, 1 32 |
| clkDiv | input | DIV_W | Half-period of `sck` in clock cycles, minus one |
| sampleValid | input | 1 | A sample pair is offered |
| sampleLeft | input | 32 | Left sample, right-aligned |
| sampleRight | input | 32 | Right sample, right-aligned |
| sampleReady | output | 1 | Pair is taken on this clock when valid |
| sck | output | 1 | Bit clock |
| ws | output | 1 | Word select, or frame sync in PCM |
| sd | output | 1 | Serial data |
| underrun | output | 1 | Sticky: a frame repeated the previous pair |
| cfgError | output | 1 | Illegal data length in use |

## Verification
The hardest state to reach is an underrun in the middle of a stream. It needs the source to stay silent for exactly one frame-load pulse and then come back. Every later frame must then pick up the pair that was skipped. The bench counts `sampleReady` pulses and withholds `sampleValid` only on a chosen pulse. It then rebuilds every sampled bit from an index that lags by one after the gap. A second hard case is a configuration change during a run, which leaves no visible trace. The bench toggles every configuration input mid-stream and checks each remaining bit against the settings captured at enable.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;

  localparam int MAX_BITS = 32;
  localparam int POS_W = 5;
  localparam int CNT_W = 6;
  localparam int LONG_SYNC_BITS = 13;

  typedef enum logic [1:0] {
    STD_PHILIPS = 2'b00,
    STD_LEFT    = 2'b01,
    STD_RIGHT   = 2'b10,
    STD_PCM     = 2'b11
  } std_e;

  typedef struct packed {
    std_e       std;
    logic       longSync;
    logic       idleHigh;
    logic [1:0] dataLen;
    logic       chan32;
  } cfg_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic             running;
    logic             clear;
    logic             load;
    logic             rightSlot;
    logic [POS_W-1:0] slotPos;
  } strobe_t;

  function automatic logic [CNT_W-1:0] dataBits(cfg_t c);
    case (c.dataLen)
      2'b01:   return CNT_W'(24);
      2'b10:   return CNT_W'(32);
      default: return CNT_W'(16);
    endcase
  endfunction

  function automatic logic slotIs32(cfg_t c);
    return (dataBits(c) != CNT_W'(16)) || c.chan32;
  endfunction

endpackage

// File: rtl/aud_tx_ctrl.sv
module aud_tx_ctrl
  import aud_tx_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  cfg_t             cfgIn,
  input  logic [DIV_W-1:0] clkDiv,
  output cfg_t             cfgQ,
  output strobe_t          strb,
  output logic             sckOut,
  output logic             wsOut,
  output logic             cfgErr
);

  localparam logic [CNT_W-1:0] LAST32 = CNT_W'(2 * MAX_BITS - 1);
  localparam logic [CNT_W-1:0] LAST16 = CNT_W'(MAX_BITS - 1);
  localparam logic [CNT_W-1:0] LONG_N = CNT_W'(LONG_SYNC_BITS);

  logic             running;
  logic             phase;
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divQ;
  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] lastBit;
  logic [CNT_W-1:0] nextCnt;
  logic             wide;
  logic             tick;
  logic             launch;
  logic             nextRight;

  assign wide    = slotIs32(cfgQ);
  assign lastBit = wide ? LAST32 : LAST16;
  assign tick    = running && (divCnt == divQ);
  assign launch  = tick && phase;
  assign nextCnt = (bitCnt == lastBit) ? '0 : bitCnt + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      phase   <= 1'b0;
      divCnt  <= '0;
      divQ    <= '0;
      bitCnt  <= '0;
      cfgQ    <= '0;
      cfgErr  <= 1'b0;
    end else if (!enable) begin
      running <= 1'b0;
      phase   <= 1'b0;
      divCnt  <= '0;
      bitCnt  <= '0;
      cfgQ    <= cfgIn;
      divQ    <= clkDiv;
      cfgErr  <= 1'b0;
    end else if (!running) begin
      running <= 1'b1;
      phase   <= 1'b0;
      divCnt  <= '0;
      bitCnt  <= lastBit;
      cfgErr  <= (cfgQ.dataLen == 2'b11);
    end else if (tick) begin
      divCnt <= '0;
      phase  <= ~phase;
      if (phase) bitCnt <= nextCnt;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  always_comb begin
    strb.running   = running;
    strb.clear     = !running;
    strb.load      = launch && (bitCnt == lastBit);
    strb.rightSlot = wide ? bitCnt[5] : bitCnt[4];
    strb.slotPos   = wide ? bitCnt[4:0] : {1'b0, bitCnt[3:0]};
  end

  assign nextRight = wide ? nextCnt[5] : nextCnt[4];
  assign sckOut    = phase ^ cfgQ.idleHigh;

  always_comb begin
    wsOut = 1'b0;
    if (running) begin
      case (cfgQ.std)
        STD_PHILIPS: wsOut = nextRight;
        STD_LEFT,
        STD_RIGHT:   wsOut = strb.rightSlot;
        default:     wsOut = cfgQ.longSync ? (bitCnt < LONG_N) : (bitCnt == lastBit);
      endcase
    end
  end

  AST_BITCNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    running |-> (bitCnt <= lastBit)); // R7
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (running && $past(running)) |-> ($stable(cfgQ) && $stable(divQ))); // R9
  AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    running |-> (divCnt <= divQ)); // R11
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> !strb.load); // R10
  AST_CFGERR_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !cfgErr); // R8

endmodule

// File: rtl/aud_tx_shift.sv
module aud_tx_shift
  import aud_tx_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strb,
  input  cfg_t                cfgQ,
  input  logic                sampleValid,
  input  logic [MAX_BITS-1:0] sampleLeft,
  input  logic [MAX_BITS-1:0] sampleRight,
  output logic                sdOut,
  output logic                underrun
);

  logic [MAX_BITS-1:0] leftQ;
  logic [MAX_BITS-1:0] rightQ;
  logic [MAX_BITS-1:0] word;
  logic [CNT_W-1:0]    nData;
  logic [CNT_W-1:0]    nSlot;
  logic [CNT_W-1:0]    posW;
  logic [POS_W-1:0]    dataTop;
  logic [POS_W-1:0]    slotTop;
  logic [POS_W-1:0]    idx;
  logic                inData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      leftQ    <= '0;
      rightQ   <= '0;
      underrun <= 1'b0;
    end else if (strb.clear) begin
      leftQ    <= '0;
      rightQ   <= '0;
      underrun <= 1'b0;
    end else if (strb.load) begin
      if (sampleValid) begin
        leftQ  <= sampleLeft;
        rightQ <= sampleRight;
      end else begin
        underrun <= 1'b1;
      end
    end
  end

  assign word    = strb.rightSlot ? rightQ : leftQ;
  assign nData   = dataBits(cfgQ);
  assign nSlot   = slotIs32(cfgQ) ? CNT_W'(32) : CNT_W'(16);
  assign posW    = {1'b0, strb.slotPos};
  assign dataTop = POS_W'(nData - 1'b1);
  assign slotTop = POS_W'(nSlot - 1'b1);

  always_comb begin
    if (cfgQ.std == STD_RIGHT) begin
      inData = (posW >= (nSlot - nData));
      idx    = slotTop - strb.slotPos;
    end else begin
      inData = (posW < nData);
      idx    = dataTop - strb.slotPos;
    end
    sdOut = strb.running && inData && word[idx];
  end

  AST_UNDERRUN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.clear && $past(underrun)) |-> underrun); // R10
  AST_REPEAT_ON_GAP: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.load && !sampleValid && !strb.clear) |-> ($stable(leftQ) && $stable(rightQ))); // R10

endmodule

// File: rtl/audio_ser_tx.sv
module audio_ser_tx
  import aud_tx_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [1:0]       cfgStd,
  input  logic             cfgLongSync,
  input  logic             cfgIdleHigh,
  input  logic [1:0]       cfgDataLen,
  input  logic             cfgChan32,
  input  logic [DIV_W-1:0] clkDiv,
  input  logic             sampleValid,
  input  logic [31:0]      sampleLeft,
  input  logic [31:0]      sampleRight,
  output logic             sampleReady,
  output logic             sck,
  output logic             ws,
  output logic             sd,
  output logic             underrun,
  output logic             cfgError
);

  cfg_t    cfgIn;
  cfg_t    cfgQ;
  strobe_t strb;

  always_comb begin
    cfgIn.std      = std_e'(cfgStd);
    cfgIn.longSync = cfgLongSync;
    cfgIn.idleHigh = cfgIdleHigh;
    cfgIn.dataLen  = cfgDataLen;
    cfgIn.chan32   = cfgChan32;
  end

  aud_tx_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .enable (enable),
    .cfgIn  (cfgIn),
    .clkDiv (clkDiv),
    .cfgQ   (cfgQ),
    .strb   (strb),
    .sckOut (sck),
    .wsOut  (ws),
    .cfgErr (cfgError)
  );

  aud_tx_shift u_shift (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .cfgQ        (cfgQ),
    .sampleValid (sampleValid),
    .sampleLeft  (sampleLeft),
    .sampleRight (sampleRight),
    .sdOut       (sd),
    .underrun    (underrun)
  );

  assign sampleReady = strb.load;

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && $past(!enable) && $stable(cfgIdleHigh)) |-> (sck == cfgIdleHigh)); // R5
  AST_SD_LAUNCH_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !$stable(sd)) |-> (sck == cfgQ.idleHigh)); // R5

endmodule

// File: tb/sim_audio_ser_tx.sv
module sim_audio_ser_tx;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic [1:0]  cfgStd = 2'b00;
  logic        cfgLongSync = 1'b0;
  logic        cfgIdleHigh = 1'b0;
  logic [1:0]  cfgDataLen = 2'b00;
  logic        cfgChan32 = 1'b0;
  logic [7:0]  clkDiv = 8'd0;
  logic        sampleValid = 1'b0;
  logic [31:0] sampleLeft = '0;
  logic [31:0] sampleRight = '0;
  logic        sampleReady, sck, ws, sd, underrun, cfgError;

  always #10 clk = ~clk;

  audio_ser_tx u0 (.*);

  int nRun = 0;
  int nFail = 0;
  bit done = 0;

  // per-case settings captured by the bench model
  int cStd, cLong, cIdle, cLen, cChan, cDiv, cGap;
  logic [31:0] bufL [16];
  logic [31:0] bufR [16];
  int  srcIdx = 0;
  int  loadCnt = 0;
  bit  advPending = 0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // source: offers pair srcIdx, withholds it on load number cGap
  initial forever begin
    @(negedge clk);
    if (advPending) srcIdx++;
    advPending  = 0;
    sampleValid = (loadCnt != cGap);
    sampleLeft  = bufL[srcIdx % 16];
    sampleRight = bufR[srcIdx % 16];
    if (sampleReady) begin
      loadCnt++;
      if (sampleValid) advPending = 1;
    end
  end

  function automatic int slotW();
    if (cLen == 1 || cLen == 2) return 32;
    return cChan ? 32 : 16;
  endfunction

  function automatic int dataW();
    if (cLen == 1) return 24;
    if (cLen == 2) return 32;
    return 16;
  endfunction

  // expected {ws, sd} for sampled bit k after enable (k = 0 is the lead-in)
  function automatic logic [1:0] expBits(int k);
    int w = slotW();
    int d = dataW();
    int pos = (k + 2 * w - 1) % (2 * w);
    int f = (k + 2 * w - 1) / (2 * w) - 1;
    int c = (pos >= w) ? 1 : 0;
    int p = pos % w;
    int idx;
    logic [31:0] word;
    logic eWs, eSd;
    idx = (cGap >= 1 && f >= cGap) ? f - 1 : f;
    word = (f < 0) ? 32'd0 : (c ? bufR[idx] : bufL[idx]);
    if (cStd == 2) eSd = (p >= w - d) ? word[w - 1 - p] : 1'b0;
    else           eSd = (p < d) ? word[d - 1 - p] : 1'b0;
    case (cStd)
      0: eWs = (((pos + 1) % (2 * w)) >= w);
      3: eWs = cLong ? (pos < 13) : (pos == 2 * w - 1);
      default: eWs = c[0];
    endcase
    return {eWs, eSd};
  endfunction

  task automatic runCase(string tag, int std, int lng, int idle, int len, int chan,
                         int div, int frames, int gap, bit wiggle);
    int total, bad, firstK, lastEv, cyc, perBad, perAct;
    logic [1:0] firstAct, firstExp, e;
    logic prevSck;
    @(posedge clk);
    enable = 1'b0;
    cStd = std; cLong = lng; cIdle = idle; cLen = len; cChan = chan; cDiv = div; cGap = gap;
    cfgStd = 2'(std); cfgLongSync = lng[0]; cfgIdleHigh = idle[0];
    cfgDataLen = 2'(len); cfgChan32 = chan[0]; clkDiv = 8'(div);
    for (int i = 0; i < 16; i++) begin
      bufL[i] = $urandom;
      bufR[i] = $urandom;
    end
    srcIdx = 0; loadCnt = 0; advPending = 0;
    repeat (3) @(negedge clk);
    check(sck == idle[0], "R5", "idle sck level while disabled", int'(sck), idle);
    enable = 1'b1;
    total = 1 + frames * 2 * slotW();
    bad = 0; firstK = -1; perBad = 0; perAct = 0; lastEv = -1; cyc = 0;
    firstAct = '0; firstExp = '0;
    prevSck = idle[0];
    for (int k = 0; k < total; ) begin
      @(negedge clk);
      cyc++;
      if (wiggle && cyc == 7) begin
        cfgStd = ~cfgStd; cfgLongSync = ~cfgLongSync; cfgDataLen = ~cfgDataLen;
        cfgChan32 = ~cfgChan32; clkDiv = clkDiv + 8'd2;
      end
      if (sck != prevSck && sck != idle[0]) begin
        e = expBits(k);
        if ({ws, sd} != e) begin
          bad++;
          if (firstK < 0) begin firstK = k; firstAct = {ws, sd}; firstExp = e; end
        end
        if (lastEv >= 0 && (cyc - lastEv) != 2 * (div + 1)) begin
          perBad++; perAct = cyc - lastEv;
        end
        lastEv = cyc;
        k++;
      end
      prevSck = sck;
    end
    check(bad == 0, tag, $sformatf("{ws,sd} at bit %0d", firstK), int'(firstAct), int'(firstExp));
    check(perBad == 0, "R11", "bit period in clocks", perAct, 2 * (div + 1));
    check(underrun == (gap >= 1), "R10", "underrun flag", int'(underrun), (gap >= 1) ? 1 : 0);
    check(cfgError == (len == 3), "R8", "config error flag", int'(cfgError), (len == 3) ? 1 : 0);
    enable = 1'b0;
    repeat (2) @(negedge clk);
    check(!underrun && !cfgError && !ws && !sd, "R12", "flags and lines after disable",
          int'({underrun, cfgError, ws, sd}), 0);
    cGap = -1;
  endtask

  initial begin
    cGap = -1;
    void'($urandom(32'd7351));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check({sck, ws, sd, sampleReady, underrun, cfgError} == 6'b0, "R12", "reset state",
          int'({sck, ws, sd, sampleReady, underrun, cfgError}), 0);
    runCase("R1", 0, 0, 0, 0, 0, 0, 3, -1, 0);  // Philips 16 in 16
    runCase("R2", 1, 0, 0, 1, 0, 1, 3, -1, 0);  // left-justified 24 in forced 32 (R7)
    runCase("R3", 2, 0, 0, 0, 1, 0, 3, -1, 0);  // right-justified 16 in 32
    runCase("R3", 2, 0, 0, 1, 0, 0, 3, -1, 0);  // right-justified 24 in 32
    runCase("R4", 3, 0, 0, 0, 0, 0, 3, -1, 0);  // PCM short sync
    runCase("R4", 3, 1, 0, 2, 0, 0, 3, -1, 0);  // PCM long sync, 32 bits
    runCase("R4", 1, 1, 0, 0, 0, 0, 2, -1, 0);  // long sync bit ignored outside PCM
    runCase("R6", 0, 0, 0, 2, 0, 0, 2, -1, 0);  // 32-bit data, Philips
    runCase("R7", 1, 0, 0, 2, 0, 0, 2, -1, 0);  // chan bit 0 ignored for 32-bit data
    runCase("R8", 1, 0, 0, 3, 0, 0, 2, -1, 0);  // illegal length sent as 16
    runCase("R10", 1, 0, 0, 0, 0, 0, 5, 2, 0);  // underrun on third load
    runCase("R9", 0, 0, 0, 0, 0, 1, 3, -1, 1);  // config wiggled while enabled
    runCase("R5", 1, 0, 1, 0, 0, 2, 2, -1, 0);  // idle-high bit clock
    for (int n = 0; n < 8; n++) begin
      int s = $urandom % 4;
      runCase(s == 0 ? "R1" : s == 1 ? "R2" : s == 2 ? "R3" : "R4",
              s, $urandom % 2, $urandom % 2, $urandom % 4, $urandom % 2,
              $urandom % 3, 3, ($urandom % 3 == 0) ? 1 : -1, 0);
    end
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      nRun++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

endmodule